// File: doc/BRIEF.md
# Load Color Selective Squash Tracker

This block sits beside an instruction scheduler and records, for every scheduler entry, which outstanding loads that entry depends on, directly or through a chain of intermediate instructions. Each outstanding load owns one color, drawn from a small pool. Each entry holds a color bit-vector. When an instruction is dispatched, its vector is the bitwise OR of the vectors of the instructions that produce its operands. A load also adds the bit of the color it is handed at dispatch.

When a load reports a cache miss, the block broadcasts that load's color. Every entry whose vector holds that bit is flagged for squash and rescheduling, and all other entries are left alone. When a load reports a hit, its color is wiped from every entry and returned to the free pool. An entry whose vector is empty depends on no unresolved load, so it is flagged as safe to leave the scheduler.

The scheduler drives one dispatch port and one load report port. It reads a per-entry squash mask, a per-entry safe mask, and the color that the next load dispatch would receive.

Top module: `color_squash_tracker`

## Requirements
- R1: After reset, every entry's vector is empty. As a result, safe_mask is all ones, squash_mask is zero, color_avail is 1 and alloc_color is 0.
- R2: A load dispatch is given the lowest-numbered free color. That color is shown on alloc_color before the dispatch edge and is no longer free after it.
- R3: A non-load dispatch writes the bitwise OR of disp_parent_a and disp_parent_b into the addressed entry, replacing whatever the entry held before.
- R4: A load dispatch writes the OR of its two parent vectors plus the bit of its own allocated color.
- R5: A miss report for color c (rpt_valid=1, rpt_miss=1) makes squash_mask, in the following cycle, equal to the set of entries whose vector holds bit c. squash_mask is zero in any cycle that does not follow a miss report.
- R6: A miss report squashes no entry whose vector lacks bit c, and it changes no vector.
- R7: A hit report for color c (rpt_valid=1, rpt_miss=0) clears bit c in every entry from the next cycle on and returns c to the free pool.
- R8: A miss report leaves its color allocated, so the color is not handed to a later load.
- R9: While no color is free, color_avail is 0 and a load dispatch is ignored: the entry is not written and no color is consumed.
- R10: safe_mask bit e is 1 exactly when entry e's vector is empty.
- R11: When a hit report for c and a dispatch whose parents carry c occur in the same cycle, the new entry does not carry c.
- R12: When a miss report for c and a dispatch whose parents carry c occur in the same cycle, the new entry is included in the resulting squash_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch into an entry this cycle |
| disp_entry | input | EW | Entry index written by the dispatch |
| disp_is_load | input | 1 | Dispatched instruction is a load and needs a color |
| disp_parent_a | input | NUM_COLORS | Color vector of the first operand producer |
| disp_parent_b | input | NUM_COLORS | Color vector of the second operand producer |
| rpt_valid | input | 1 | A load outcome is reported this cycle |
| rpt_miss | input | 1 | 1 = miss, 0 = hit |
| rpt_color | input | CW | Color of the reporting load |
| color_avail | output | 1 | At least one color is free |
| alloc_color | output | CW | Color the next load dispatch receives |
| squash_mask | output | NUM_ENTRIES | Entries to squash, valid the cycle after a miss |
| safe_mask | output | NUM_ENTRIES | Entries holding no unresolved color |

## Verification
The hardest cases to reach are those where the color pool is exhausted, and where a report and a dispatch collide on the same color in the same cycle.

The stimulus first builds a chain in which a load depends on an earlier load. It then dispatches loads until all eight colors are held, and tries one more load. After that it fires a hit and a miss, each in the same cycle as a dispatch whose parents carry the reported color.

No port exposes the vectors directly. The bench therefore reads them out by issuing a miss for each color in turn, since a miss alters no state, and comparing each resulting squash mask against a reference model.

// File: rtl/color_squash_tracker.sv
module color_squash_tracker #(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_COLORS  = 8,
  localparam int EW = $clog2(NUM_ENTRIES),
  localparam int CW = $clog2(NUM_COLORS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   disp_valid,
  input  logic [EW-1:0]          disp_entry,
  input  logic                   disp_is_load,
  input  logic [NUM_COLORS-1:0]  disp_parent_a,
  input  logic [NUM_COLORS-1:0]  disp_parent_b,
  input  logic                   rpt_valid,
  input  logic                   rpt_miss,
  input  logic [CW-1:0]          rpt_color,
  output logic                   color_avail,
  output logic [CW-1:0]          alloc_color,
  output logic [NUM_ENTRIES-1:0] squash_mask,
  output logic [NUM_ENTRIES-1:0] safe_mask
);

  logic [NUM_COLORS-1:0]  vec_q [NUM_ENTRIES];
  logic [NUM_COLORS-1:0]  free_q;
  logic [NUM_ENTRIES-1:0] squash_q;
  logic [NUM_ENTRIES-1:0] squash_d;

  always_comb begin
    alloc_color = '0;
    for (int i = NUM_COLORS - 1; i >= 0; i--)
      if (free_q[i]) alloc_color = CW'(i);
  end

  assign color_avail = |free_q;

  logic                  write_ok;
  logic                  take_color;
  logic [NUM_COLORS-1:0] own_bit;
  logic [NUM_COLORS-1:0] write_vec;
  logic [NUM_COLORS-1:0] hit_bit;
  logic [NUM_COLORS-1:0] miss_bit;

  assign write_ok   = disp_valid & (~disp_is_load | color_avail);
  assign take_color = write_ok & disp_is_load;
  assign own_bit    = take_color ? (NUM_COLORS'(1) << alloc_color) : '0;
  assign write_vec  = disp_parent_a | disp_parent_b | own_bit;
  assign hit_bit    = (rpt_valid & ~rpt_miss) ? (NUM_COLORS'(1) << rpt_color) : '0;
  assign miss_bit   = (rpt_valid &  rpt_miss) ? (NUM_COLORS'(1) << rpt_color) : '0;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic [NUM_COLORS-1:0] next_vec;
    assign next_vec    = ((write_ok && disp_entry == EW'(e)) ? write_vec : vec_q[e]) & ~hit_bit;
    assign squash_d[e] = |(next_vec & miss_bit);
    assign safe_mask[e] = ~|vec_q[e];

    always_ff @(posedge clk) begin
      if (!rst_n) vec_q[e] <= '0;
      else        vec_q[e] <= next_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q   <= '1;
      squash_q <= '0;
    end else begin
      free_q   <= (free_q & ~own_bit) | hit_bit;
      squash_q <= squash_d;
    end
  end

  assign squash_mask = squash_q;

endmodule

// File: rtl/color_squash_tracker_chk.sv
module color_squash_tracker_chk #(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_COLORS  = 8,
  localparam int EW = $clog2(NUM_ENTRIES),
  localparam int CW = $clog2(NUM_COLORS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   disp_valid,
  input logic                   disp_is_load,
  input logic                   rpt_valid,
  input logic                   rpt_miss,
  input logic [CW-1:0]          rpt_color,
  input logic                   color_avail,
  input logic [CW-1:0]          alloc_color,
  input logic [NUM_ENTRIES-1:0] squash_mask,
  input logic [NUM_ENTRIES-1:0] safe_mask,
  input logic [NUM_COLORS-1:0]  free_q
);

  // R5
  squash_after_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rpt_valid && rpt_miss) |=> squash_mask == '0);

  // R10
  squash_not_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_mask & safe_mask) == '0);

  // R7
  hit_frees_color_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !rpt_miss) |=> free_q[$past(rpt_color)]);

  // R8
  miss_keeps_color_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && rpt_miss && !free_q[rpt_color]) |=> !free_q[$past(rpt_color)]);

  // R9
  no_color_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_is_load && !color_avail && !(rpt_valid && !rpt_miss)) |=> $stable(free_q));

  // R2
  alloc_is_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    color_avail |-> free_q[alloc_color]);

endmodule

bind color_squash_tracker color_squash_tracker_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .NUM_COLORS(NUM_COLORS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_is_load(disp_is_load),
  .rpt_valid(rpt_valid), .rpt_miss(rpt_miss), .rpt_color(rpt_color),
  .color_avail(color_avail), .alloc_color(alloc_color),
  .squash_mask(squash_mask), .safe_mask(safe_mask), .free_q(free_q)
);

// File: tb/color_squash_tracker_tb_top.sv
module color_squash_tracker_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       disp_valid = 1'b0;
  logic [2:0] disp_entry = '0;
  logic       disp_is_load = 1'b0;
  logic [7:0] disp_parent_a = '0;
  logic [7:0] disp_parent_b = '0;
  logic       rpt_valid = 1'b0;
  logic       rpt_miss = 1'b0;
  logic [2:0] rpt_color = '0;
  logic       color_avail;
  logic [2:0] alloc_color;
  logic [7:0] squash_mask;
  logic [7:0] safe_mask;

  always #5 clk = ~clk;

  color_squash_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_entry(disp_entry),
    .disp_is_load(disp_is_load), .disp_parent_a(disp_parent_a), .disp_parent_b(disp_parent_b),
    .rpt_valid(rpt_valid), .rpt_miss(rpt_miss), .rpt_color(rpt_color),
    .color_avail(color_avail), .alloc_color(alloc_color),
    .squash_mask(squash_mask), .safe_mask(safe_mask)
  );

  typedef struct {
    logic [7:0] sq;
    logic [7:0] sf;
    logic       av;
    logic [2:0] al;
    string      req;
  } exp_t;

  exp_t       exp_q[$];
  int         checks = 0;
  int         errors = 0;
  logic [7:0] m_vec [8];
  logic [7:0] m_free;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] m_lowest(input logic [7:0] f);
    logic [2:0] r = '0;
    for (int i = 7; i >= 0; i--) if (f[i]) r = 3'(i);
    return r;
  endfunction

  task automatic step(input logic dv, input logic [2:0] ent, input logic ld,
                      input logic [7:0] pa, input logic [7:0] pb,
                      input logic rv, input logic rm, input logic [2:0] rc,
                      input string req);
    exp_t       it;
    logic       av;
    logic [2:0] al;
    logic [7:0] v;
    @(negedge clk);
    disp_valid = dv; disp_entry = ent; disp_is_load = ld;
    disp_parent_a = pa; disp_parent_b = pb;
    rpt_valid = rv; rpt_miss = rm; rpt_color = rc;
    av = |m_free;
    al = m_lowest(m_free);
    if (dv && ld && av) check("R2", {5'd0, alloc_color}, {5'd0, al}, "alloc_color before dispatch");
    it.sq = '0;
    for (int e = 0; e < 8; e++) begin
      v = m_vec[e];
      if (dv && ent == 3'(e) && !(ld && !av)) v = pa | pb | (ld ? (8'd1 << al) : 8'd0);
      if (rv && !rm) v[rc] = 1'b0;
      if (rv && rm && v[rc]) it.sq[e] = 1'b1;
      m_vec[e] = v;
    end
    if (dv && ld && av) m_free[al] = 1'b0;
    if (rv && !rm) m_free[rc] = 1'b1;
    for (int e = 0; e < 8; e++) it.sf[e] = (m_vec[e] == 8'd0);
    it.av = |m_free;
    it.al = m_lowest(m_free);
    it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic idle(input string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic miss(input logic [2:0] c, input string req);
    step(0, 0, 0, 0, 0, 1, 1, c, req);
  endtask

  task automatic hit(input logic [2:0] c, input string req);
    step(0, 0, 0, 0, 0, 1, 0, c, req);
  endtask

  always @(posedge clk) begin
    exp_t it;
    #3;
    if (exp_q.size() > 0) begin
      it = exp_q.pop_front();
      check(it.req, squash_mask, it.sq, "squash_mask");
      check(it.req, safe_mask, it.sf, "safe_mask");
      check(it.req, {7'd0, color_avail}, {7'd0, it.av}, "color_avail");
      check(it.req, {5'd0, alloc_color}, {5'd0, it.al}, "alloc_color");
    end
  end

  logic done = 1'b0;

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 8; e++) m_vec[e] = '0;
    m_free = '1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", safe_mask, 8'hff, "safe_mask");
    check("R1", squash_mask, 8'h00, "squash_mask");
    check("R1", {7'd0, color_avail}, 8'd1, "color_avail");
    check("R1", {5'd0, alloc_color}, 8'd0, "alloc_color");

    // R2 R4: load in entry 0 takes color 0
    step(1, 0, 1, 8'h00, 8'h00, 0, 0, 0, "R4");
    // R3: child of load 0
    step(1, 1, 0, 8'h01, 8'h00, 0, 0, 0, "R3");
    // R4: load depending on load 0 takes color 1
    step(1, 2, 1, 8'h00, 8'h01, 0, 0, 0, "R4");
    // R3 independent, R10 safe
    step(1, 3, 0, 8'h00, 8'h00, 0, 0, 0, "R10");
    step(1, 4, 0, 8'h02, 8'h01, 0, 0, 0, "R3");
    // R5 R6 R8: miss on color 0
    miss(0, "R5");
    idle("R5");
    miss(1, "R6");
    // R7: hit on color 0
    hit(0, "R7");
    miss(0, "R7");
    miss(1, "R7");
    // R2 fill the pool
    step(1, 3, 1, 8'h00, 8'h00, 0, 0, 0, "R2");
    step(1, 5, 1, 8'h02, 8'h00, 0, 0, 0, "R2");
    step(1, 6, 1, 8'h00, 8'h00, 0, 0, 0, "R2");
    step(1, 7, 1, 8'h00, 8'h04, 0, 0, 0, "R2");
    step(1, 0, 1, 8'h00, 8'h00, 0, 0, 0, "R2");
    step(1, 1, 1, 8'h00, 8'h00, 0, 0, 0, "R2");
    step(1, 4, 1, 8'h00, 8'h00, 0, 0, 0, "R2");
    // R9: no free color, load ignored
    step(1, 3, 1, 8'hf0, 8'h00, 0, 0, 0, "R9");
    miss(0, "R9");
    // R11: hit and dispatch collide
    step(1, 6, 0, 8'h10, 8'h04, 1, 0, 4, "R11");
    miss(4, "R11");
    miss(2, "R11");
    // R12: miss and dispatch collide
    step(1, 1, 0, 8'h20, 8'h00, 1, 1, 5, "R12");
    // R8: missed color stays held
    step(1, 2, 1, 8'h00, 8'h00, 0, 0, 0, "R8");
    for (int c = 0; c < 8; c++) miss(3'(c), "R6");
    // R7 R10: release everything
    for (int c = 0; c < 8; c++) hit(3'(c), "R10");
    for (int c = 0; c < 8; c++) miss(3'(c), "R7");
    idle("R10");
    repeat (3) @(posedge clk);
    #5;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule